// File: doc/BRIEF.md
# Multi-Level Interrupt Acceptance and State Save Unit

This unit decides when an in-order core must leave its current instruction stream for an interrupt, and at which priority level. It holds a register of pending lines, fed by a software set/clear path and by timer-compare inputs. It also holds an enable mask and a processor status word with three parts: a 4-bit interrupt-level field in bits 3:0, an exception-mode flag in bit 4 and a user-mode flag in bit 5. Each line has a fixed priority level, given by a parameter table. Every cycle the unit looks for the highest-level line that is pending, enabled and allowed by the status word.

When it accepts an interrupt, the unit pulses a vector request that carries the level. It updates the status word and writes the old status and the interrupted address into a save slot that belongs to that level alone. Level 1 is the ordinary level: it only sets exception mode and loads a cause code. Higher levels also lift the level field to their own level, so they can nest over level-1 handlers.

The core issues status operations through a single operation port: raise-level-and-read, wait-for-interrupt, return-from-level, a direct status write, and a save-slot write. A read port exposes any save slot one cycle after it is addressed.

Top module: `irq_dispatcher`

## Requirements
- R1: After reset the status word, pending register, enable mask, cause, waiting flag and request pulse are all zero.
- R2: A software set writes ones into the pending bits of non-timer lines, and a software clear removes them; when both name the same bit in one cycle, the clear wins. The pending output shows the result one cycle after the write.
- R3: Timer lines (parameter mask; line 4 and line 6 by default) follow the timer-compare input with a one-cycle delay; neither the software set port nor the software clear port changes them.
- R4: A pending line whose enable bit is zero is never accepted, and a line cleared before it is enabled is not accepted afterwards.
- R5: A line is accepted only when it is pending, enabled and its level is strictly above status bits 3:0, in whichever order those conditions become true; acceptance appears one cycle after all three hold, as a one-cycle take pulse carrying the level.
- R6: Accepting a level-1 line sets status bit 4, leaves bits 3:0 and all other bits unchanged (bits 4:0 read 0x10 from a clean state) and loads the cause output with 4.
- R7: Accepting a line of level n>1 sets status bit 4 and writes n into bits 3:0. It stores the old status and the cur_pc value into the save slot of level n and leaves the cause unchanged.
- R8: When lines of several levels are eligible together, the highest level is accepted.
- R9: While status bit 4 is set, no level-1 line is accepted; a line whose level is above bits 3:0 and above 1 still is.
- R10: Raise (op code 1) returns the whole old status word on op_rdata_o, writes op_level into bits 3:0 and keeps every other status bit.
- R11: Return (op code 3) loads the status word from the save slot of op_level and presents that slot's address on resume_pc_o with a one-cycle resume pulse. Save write (op code 5) stores op_data and op_pc into slot op_level, and direct status write (op code 4) loads op_data into the status word, so a restored value such as 0x40006 reads back exactly.
- R12: Wait (op code 2) writes op_level into bits 3:0 and raises waiting_o, which stays high until an interrupt is accepted; a set user-mode bit (bit 5) does not prevent acceptance.
- R13: In a cycle with op_valid high no interrupt is accepted; an eligible line is taken in the first cycle without an operation.
- R14: The save read port returns the status and address stored for save_rd_level one cycle after the level is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_set_we | input | 1 | Software set strobe |
| sw_set_bits | input | NUM_LINES | Lines to mark pending |
| sw_clr_we | input | 1 | Software clear strobe |
| sw_clr_bits | input | NUM_LINES | Lines to remove from pending |
| timer_hit | input | NUM_LINES | Timer-compare request per line (only timer lines used) |
| en_we | input | 1 | Enable mask write strobe |
| en_bits | input | NUM_LINES | New enable mask |
| op_valid | input | 1 | Status operation valid |
| op_code | input | 3 | 1 raise, 2 wait, 3 return, 4 status write, 5 save write |
| op_level | input | 4 | Level operand of the operation |
| op_data | input | STAT_W | Status value for status write and save write |
| op_pc | input | PC_W | Address value for save write |
| cur_pc | input | PC_W | Address of the interrupted instruction |
| save_rd_level | input | 4 | Save slot selected for readout |
| pending_o | output | NUM_LINES | Pending register |
| enable_o | output | NUM_LINES | Enable mask |
| status_o | output | STAT_W | Status word |
| cause_o | output | CAUSE_W | Cause code |
| op_rdata_o | output | STAT_W | Old status returned by raise |
| take_valid_o | output | 1 | One-cycle interrupt request |
| take_level_o | output | 4 | Level of the accepted interrupt |
| waiting_o | output | 1 | Core is stalled in wait |
| resume_valid_o | output | 1 | One-cycle return pulse |
| resume_pc_o | output | PC_W | Address to resume at |
| save_rd_status_o | output | STAT_W | Saved status of the selected slot |
| save_rd_pc_o | output | PC_W | Saved address of the selected slot |

## Verification
The hardest situation to reach is an operation cycle in which a line is already eligible. Only the operation itself can lower the level field, so the line only becomes acceptable after the op has run. The stimulus first raises the level to 7 and arms a level-3 line, then issues two raise-to-0 operations in a row. The second one runs while the line is eligible and must hold the request off for exactly that cycle. Nested acceptance under exception mode is reached by leaving a level-1 line pending while a level-2 line is set. A random phase with all enables off mixes set, clear and timer inputs to exercise the pending rules and the no-accept rule together.

// File: rtl/irq_disp_pkg.sv
`timescale 1ns/1ps
package irq_disp_pkg;
  localparam int LVL_W      = 4;
  localparam int EXCM_BIT   = 4;
  localparam int USER_BIT   = 5;
  localparam int CAUSE_LVL1 = 4;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_RAISE     = 3'd1,
    OP_WAIT      = 3'd2,
    OP_RETURN    = 3'd3,
    OP_WR_STATUS = 3'd4,
    OP_WR_SAVE   = 3'd5
  } op_e;
endpackage

// File: rtl/irq_pending.sv
`timescale 1ns/1ps
module irq_pending #(
  parameter int                 NUM_LINES  = 8,
  parameter logic [NUM_LINES-1:0] TIMER_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_we,
  input  logic [NUM_LINES-1:0] set_bits,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] clr_bits,
  input  logic [NUM_LINES-1:0] timer_hit,
  input  logic                 en_we,
  input  logic [NUM_LINES-1:0] en_bits,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] en_q
);
  logic [NUM_LINES-1:0] set_m, clr_m, soft_next;

  always_comb begin
    set_m     = set_we ? set_bits : '0;
    clr_m     = clr_we ? clr_bits : '0;
    // clear applied after set: clear wins on a shared bit
    soft_next = (pend_q | set_m) & ~clr_m & ~TIMER_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= soft_next | (timer_hit & TIMER_MASK);
      if (en_we) en_q <= en_bits;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_disp_pkg::*;
#(
  parameter int                         NUM_LINES   = 8,
  parameter logic [NUM_LINES*LVL_W-1:0] LINE_LEVELS = '0
) (
  input  logic [NUM_LINES-1:0] active,
  input  logic [LVL_W-1:0]     cur_lvl,
  input  logic                 excm,
  output logic                 hit,
  output logic [LVL_W-1:0]     best_lvl
);
  logic [NUM_LINES-1:0] elig;
  logic [LVL_W-1:0]     line_lvl [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign line_lvl[i] = LINE_LEVELS[i*LVL_W +: LVL_W];
    assign elig[i] = active[i] && (line_lvl[i] > cur_lvl) &&
                     !(excm && (line_lvl[i] == LVL_W'(1)));
  end

  always_comb begin
    best_lvl = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (elig[i] && (line_lvl[i] > best_lvl)) best_lvl = line_lvl[i];
    end
    hit = |elig;
  end
endmodule

// File: rtl/irq_save_bank.sv
`timescale 1ns/1ps
module irq_save_bank #(
  parameter int ADDR_W = 4,
  parameter int STAT_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [STAT_W-1:0] wstat,
  input  logic [PC_W-1:0]   wpc,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [STAT_W-1:0] ret_stat,
  output logic [PC_W-1:0]   ret_pc,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [STAT_W-1:0] rd_stat,
  output logic [PC_W-1:0]   rd_pc
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [STAT_W-1:0] stat_mem [DEPTH];
  logic [PC_W-1:0]   pc_mem   [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      stat_mem[i] = '0;
      pc_mem[i]   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      stat_mem[waddr] <= wstat;
      pc_mem[waddr]   <= wpc;
    end
    rd_stat <= stat_mem[rd_addr];
    rd_pc   <= pc_mem[rd_addr];
  end

  assign ret_stat = stat_mem[ret_addr];
  assign ret_pc   = pc_mem[ret_addr];
endmodule

// File: rtl/irq_dispatcher.sv
`timescale 1ns/1ps
module irq_dispatcher
  import irq_disp_pkg::*;
#(
  parameter int                         NUM_LINES   = 8,
  parameter int                         STAT_W      = 32,
  parameter int                         PC_W        = 32,
  parameter int                         CAUSE_W     = 8,
  parameter logic [NUM_LINES*LVL_W-1:0] LINE_LEVELS = 32'h6241_3211,
  parameter logic [NUM_LINES-1:0]       TIMER_MASK  = 8'h50
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sw_set_we,
  input  logic [NUM_LINES-1:0] sw_set_bits,
  input  logic                 sw_clr_we,
  input  logic [NUM_LINES-1:0] sw_clr_bits,
  input  logic [NUM_LINES-1:0] timer_hit,
  input  logic                 en_we,
  input  logic [NUM_LINES-1:0] en_bits,
  input  logic                 op_valid,
  input  logic [2:0]           op_code,
  input  logic [LVL_W-1:0]     op_level,
  input  logic [STAT_W-1:0]    op_data,
  input  logic [PC_W-1:0]      op_pc,
  input  logic [PC_W-1:0]      cur_pc,
  input  logic [LVL_W-1:0]     save_rd_level,
  output logic [NUM_LINES-1:0] pending_o,
  output logic [NUM_LINES-1:0] enable_o,
  output logic [STAT_W-1:0]    status_o,
  output logic [CAUSE_W-1:0]   cause_o,
  output logic [STAT_W-1:0]    op_rdata_o,
  output logic                 take_valid_o,
  output logic [LVL_W-1:0]     take_level_o,
  output logic                 waiting_o,
  output logic                 resume_valid_o,
  output logic [PC_W-1:0]      resume_pc_o,
  output logic [STAT_W-1:0]    save_rd_status_o,
  output logic [PC_W-1:0]      save_rd_pc_o
);
  op_e                op;
  logic               hit, take;
  logic [LVL_W-1:0]   best_lvl;
  logic               sv_we;
  logic [LVL_W-1:0]   sv_addr;
  logic [STAT_W-1:0]  sv_stat, ret_stat;
  logic [PC_W-1:0]    sv_pc, ret_pc;

  assign op = op_e'(op_code);

  irq_pending #(.NUM_LINES(NUM_LINES), .TIMER_MASK(TIMER_MASK)) u_pend (
    .clk(clk), .rst(rst),
    .set_we(sw_set_we), .set_bits(sw_set_bits),
    .clr_we(sw_clr_we), .clr_bits(sw_clr_bits),
    .timer_hit(timer_hit),
    .en_we(en_we), .en_bits(en_bits),
    .pend_q(pending_o), .en_q(enable_o)
  );

  irq_arbiter #(.NUM_LINES(NUM_LINES), .LINE_LEVELS(LINE_LEVELS)) u_arb (
    .active(pending_o & enable_o),
    .cur_lvl(status_o[LVL_W-1:0]),
    .excm(status_o[EXCM_BIT]),
    .hit(hit),
    .best_lvl(best_lvl)
  );

  // operations own the cycle; acceptance waits for a free one
  assign take = hit && !op_valid;

  always_comb begin
    sv_we   = take || (op_valid && op == OP_WR_SAVE);
    sv_addr = take ? best_lvl : op_level;
    sv_stat = take ? status_o : op_data;
    sv_pc   = take ? cur_pc   : op_pc;
  end

  irq_save_bank #(.ADDR_W(LVL_W), .STAT_W(STAT_W), .PC_W(PC_W)) u_save (
    .clk(clk),
    .we(sv_we), .waddr(sv_addr), .wstat(sv_stat), .wpc(sv_pc),
    .ret_addr(op_level), .ret_stat(ret_stat), .ret_pc(ret_pc),
    .rd_addr(save_rd_level), .rd_stat(save_rd_status_o), .rd_pc(save_rd_pc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o       <= '0;
      cause_o        <= '0;
      op_rdata_o     <= '0;
      take_valid_o   <= 1'b0;
      take_level_o   <= '0;
      waiting_o      <= 1'b0;
      resume_valid_o <= 1'b0;
      resume_pc_o    <= '0;
    end else begin
      take_valid_o   <= 1'b0;
      resume_valid_o <= 1'b0;
      if (op_valid) begin
        case (op)
          OP_RAISE: begin
            op_rdata_o               <= status_o;
            status_o[LVL_W-1:0]      <= op_level;
          end
          OP_WAIT: begin
            status_o[LVL_W-1:0]      <= op_level;
            waiting_o                <= 1'b1;
          end
          OP_RETURN: begin
            status_o                 <= ret_stat;
            resume_pc_o              <= ret_pc;
            resume_valid_o           <= 1'b1;
          end
          OP_WR_STATUS: status_o     <= op_data;
          default: ;
        endcase
      end else if (take) begin
        take_valid_o         <= 1'b1;
        take_level_o         <= best_lvl;
        waiting_o            <= 1'b0;
        status_o[EXCM_BIT]   <= 1'b1;
        if (best_lvl == LVL_W'(1)) cause_o <= CAUSE_W'(CAUSE_LVL1);
        else                       status_o[LVL_W-1:0] <= best_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_dispatcher_chk.sv
`timescale 1ns/1ps
module irq_dispatcher_chk #(
  parameter int                   NUM_LINES  = 8,
  parameter int                   STAT_W     = 32,
  parameter logic [NUM_LINES-1:0] TIMER_MASK = 8'h50
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 op_valid,
  input logic [2:0]           op_code,
  input logic [3:0]           op_level,
  input logic [NUM_LINES-1:0] timer_hit,
  input logic [NUM_LINES-1:0] pending_o,
  input logic [NUM_LINES-1:0] enable_o,
  input logic [STAT_W-1:0]    status_o,
  input logic [STAT_W-1:0]    op_rdata_o,
  input logic                 take_valid_o,
  input logic [3:0]           take_level_o,
  input logic                 waiting_o
);
  assert_timer_follow_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pending_o & TIMER_MASK) == ($past(timer_hit) & TIMER_MASK)));

  assert_take_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    take_valid_o |-> (($past(pending_o) & $past(enable_o)) != '0));

  assert_take_above_level_R5: assert property (@(posedge clk) disable iff (rst)
    take_valid_o |-> (take_level_o > $past(status_o[3:0])));

  assert_take_sets_excm_R6: assert property (@(posedge clk) disable iff (rst)
    take_valid_o |-> status_o[4]);

  assert_high_level_field_R7: assert property (@(posedge clk) disable iff (rst)
    (take_valid_o && take_level_o > 4'd1) |-> (status_o[3:0] == take_level_o));

  assert_lvl1_blocked_in_excm_R9: assert property (@(posedge clk) disable iff (rst)
    (take_valid_o && take_level_o == 4'd1) |->
      (!$past(status_o[4]) && status_o[3:0] == $past(status_o[3:0])));

  assert_raise_keeps_rest_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd1) |=>
      (op_rdata_o == $past(status_o) && status_o[3:0] == $past(op_level) &&
       status_o[STAT_W-1:4] == $past(status_o[STAT_W-1:4])));

  assert_wait_sets_flag_R12: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd2) |=> (waiting_o && status_o[3:0] == $past(op_level)));

  assert_op_blocks_take_R13: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !take_valid_o);
endmodule

bind irq_dispatcher irq_dispatcher_chk #(
  .NUM_LINES(NUM_LINES), .STAT_W(STAT_W), .TIMER_MASK(TIMER_MASK)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .op_level(op_level), .timer_hit(timer_hit), .pending_o(pending_o),
  .enable_o(enable_o), .status_o(status_o), .op_rdata_o(op_rdata_o),
  .take_valid_o(take_valid_o), .take_level_o(take_level_o),
  .waiting_o(waiting_o)
);

// File: tb/irq_dispatcher_bench.sv
`timescale 1ns/1ps
module irq_dispatcher_bench;
  localparam int         NL = 8;
  localparam logic [7:0] TM = 8'h50;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_set_we = 0, sw_clr_we = 0, en_we = 0, op_valid = 0;
  logic [7:0]  sw_set_bits = 0, sw_clr_bits = 0, timer_hit = 0, en_bits = 0;
  logic [2:0]  op_code = 0;
  logic [3:0]  op_level = 0, save_rd_level = 0;
  logic [31:0] op_data = 0, op_pc = 0, cur_pc = 0;
  logic [7:0]  pending_o, enable_o, cause_o;
  logic [31:0] status_o, op_rdata_o, resume_pc_o, save_rd_status_o, save_rd_pc_o;
  logic        take_valid_o, waiting_o, resume_valid_o;
  logic [3:0]  take_level_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  always #2.5 clk = ~clk;

  irq_dispatcher u_irq_dispatcher (
    .clk(clk), .rst(rst),
    .sw_set_we(sw_set_we), .sw_set_bits(sw_set_bits),
    .sw_clr_we(sw_clr_we), .sw_clr_bits(sw_clr_bits),
    .timer_hit(timer_hit), .en_we(en_we), .en_bits(en_bits),
    .op_valid(op_valid), .op_code(op_code), .op_level(op_level),
    .op_data(op_data), .op_pc(op_pc), .cur_pc(cur_pc),
    .save_rd_level(save_rd_level),
    .pending_o(pending_o), .enable_o(enable_o), .status_o(status_o),
    .cause_o(cause_o), .op_rdata_o(op_rdata_o),
    .take_valid_o(take_valid_o), .take_level_o(take_level_o),
    .waiting_o(waiting_o), .resume_valid_o(resume_valid_o),
    .resume_pc_o(resume_pc_o), .save_rd_status_o(save_rd_status_o),
    .save_rd_pc_o(save_rd_pc_o)
  );

  function automatic logic [7:0] next_pend(input logic [7:0] p, input logic swe,
      input logic [7:0] sb, input logic cwe, input logic [7:0] cb, input logic [7:0] th);
    logic [7:0] s, c;
    s = swe ? sb : 8'h00;
    c = cwe ? cb : 8'h00;
    return (((p | s) & ~c) & ~TM) | (th & TM);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_op(input logic [2:0] code, input logic [3:0] lvl,
                       input logic [31:0] data, input logic [31:0] pc);
    op_valid = 1; op_code = code; op_level = lvl; op_data = data; op_pc = pc;
    tick();
    op_valid = 0;
  endtask

  task automatic sw_set(input logic [7:0] b);
    sw_set_we = 1; sw_set_bits = b; tick(); sw_set_we = 0;
  endtask

  task automatic sw_clr(input logic [7:0] b);
    sw_clr_we = 1; sw_clr_bits = b; tick(); sw_clr_we = 0;
  endtask

  task automatic set_en(input logic [7:0] b);
    en_we = 1; en_bits = b; tick(); en_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] model;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 status", status_o, 0);
    chk("R1 pending", pending_o, 0);
    chk("R1 enable", enable_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 take", take_valid_o, 0);
    chk("R1 waiting", waiting_o, 0);

    // R2 R3 R4 random pending traffic, all enables off
    model = 8'h00;
    for (int i = 0; i < 400; i++) begin
      sw_set_we = 1'($urandom); sw_set_bits = 8'($urandom);
      sw_clr_we = 1'($urandom); sw_clr_bits = 8'($urandom);
      timer_hit = 8'($urandom);
      tick();
      model = next_pend(model, sw_set_we, sw_set_bits, sw_clr_we, sw_clr_bits, timer_hit);
      chk("R2/R3 pending random", pending_o, model);
      chk("R4 no take while disabled", take_valid_o, 0);
    end
    sw_set_we = 0; sw_clr_we = 0; timer_hit = 0;
    sw_clr(8'hFF);
    chk("R2 clear all", pending_o, 0);

    // R2 clear wins over set on the same bit
    sw_set_we = 1; sw_clr_we = 1; sw_set_bits = 8'h02; sw_clr_bits = 8'h02;
    tick();
    sw_set_we = 0; sw_clr_we = 0;
    chk("R2 clear wins", pending_o, 0);

    // R4 pending but disabled; cleared before enabling
    sw_set(8'h01);
    chk("R2 set visible", pending_o, 8'h01);
    repeat (3) tick();
    chk("R4 disabled not taken", take_valid_o, 0);
    sw_clr(8'h01);
    set_en(8'h01);
    tick(); tick();
    chk("R4 cleared before enable", take_valid_o, 0);
    chk("R4 status unchanged", status_o, 0);

    // R5 R6 level-1 acceptance
    cur_pc = 32'h1000_0040;
    sw_set(8'h01);
    chk("R5 not yet", take_valid_o, 0);
    tick();
    chk("R5 take", take_valid_o, 1);
    chk("R5 level", take_level_o, 1);
    chk("R6 status", status_o, 32'h10);
    chk("R6 cause", cause_o, 4);
    tick();
    chk("R5 pulse", take_valid_o, 0);
    chk("R9 no level-1 retake", status_o, 32'h10);

    // R7 R9 R14 nested level 2 over exception mode
    set_en(8'h05);
    sw_set(8'h04);
    tick();
    chk("R9 higher level nests", take_valid_o, 1);
    chk("R7 level", take_level_o, 2);
    chk("R7 status", status_o, 32'h12);
    chk("R7 cause kept", cause_o, 4);
    save_rd_level = 4'd2;
    tick();
    chk("R14 saved status", save_rd_status_o, 32'h10);
    chk("R14 saved pc", save_rd_pc_o, 32'h1000_0040);

    // R11 return from level 2
    sw_clr(8'h05);
    do_op(3'd3, 4'd2, 0, 0);
    chk("R11 status restored", status_o, 32'h10);
    chk("R11 resume pulse", resume_valid_o, 1);
    chk("R11 resume pc", resume_pc_o, 32'h1000_0040);
    tick();
    chk("R11 resume one cycle", resume_valid_o, 0);

    // R10 R5 R13 level raised before enable, then lowered
    do_op(3'd4, 0, 32'h0004_0020, 0);
    chk("R11 status write", status_o, 32'h0004_0020);
    do_op(3'd1, 4'd7, 0, 0);
    chk("R10 old status", op_rdata_o, 32'h0004_0020);
    chk("R10 new status", status_o, 32'h0004_0027);
    set_en(8'h08);
    sw_set(8'h08);
    tick();
    chk("R5 level too low", take_valid_o, 0);
    do_op(3'd1, 4'd0, 0, 0);
    chk("R10 old status 2", op_rdata_o, 32'h0004_0027);
    chk("R10 lowered", status_o, 32'h0004_0020);
    do_op(3'd1, 4'd0, 0, 0);
    chk("R13 op holds take", take_valid_o, 0);
    chk("R10 old status 3", op_rdata_o, 32'h0004_0020);
    tick();
    chk("R13 take after op", take_valid_o, 1);
    chk("R5 level 3", take_level_o, 3);
    chk("R7 user bit kept", status_o, 32'h0004_0033);

    // R8 highest level wins
    sw_clr(8'hFF);
    do_op(3'd4, 0, 0, 0);
    set_en(8'hAF);
    cur_pc = 32'h2000_0000;
    sw_set(8'h25);
    tick();
    chk("R8 take", take_valid_o, 1);
    chk("R8 highest", take_level_o, 4);
    chk("R8 status", status_o, 32'h14);
    sw_set(8'h80);
    tick();
    chk("R8 level 6", take_level_o, 6);
    chk("R7 status 6", status_o, 32'h16);
    save_rd_level = 4'd6;
    tick();
    chk("R14 slot 6 status", save_rd_status_o, 32'h14);
    chk("R14 slot 6 pc", save_rd_pc_o, 32'h2000_0000);

    // R11 save write then return
    sw_clr(8'hFF);
    do_op(3'd5, 4'd6, 32'h0004_0006, 32'h3000_0010);
    do_op(3'd3, 4'd6, 0, 0);
    chk("R11 exact restore", status_o, 32'h0004_0006);
    chk("R11 resume pc 6", resume_pc_o, 32'h3000_0010);

    // R12 wait with user bit set
    do_op(3'd4, 0, 32'h20, 0);
    set_en(8'h01);
    do_op(3'd2, 4'd0, 0, 0);
    chk("R12 waiting", waiting_o, 1);
    chk("R12 status", status_o, 32'h20);
    tick(); tick();
    chk("R12 still waiting", waiting_o, 1);
    sw_set(8'h01);
    tick();
    chk("R12 take from wait", take_valid_o, 1);
    chk("R12 wait released", waiting_o, 0);
    chk("R12 status user", status_o, 32'h30);

    // R3 timer lines ignore the software ports
    sw_clr(8'hFF);
    sw_set(8'h10);
    chk("R3 set port ignored", pending_o, 0);
    timer_hit = 8'h10;
    tick();
    chk("R3 timer sets", pending_o, 8'h10);
    sw_clr(8'h10);
    chk("R3 clear port ignored", pending_o, 8'h10);
    timer_hit = 0;
    tick();
    chk("R3 timer drops", pending_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule